// File: doc/BRIEF.md
# Pointer Justification Event Counter

This block tallies pointer justification activity for a single tributary. Positive adjustments and negative adjustments each drive their own pulse input, and each pulse type has a private 4-bit running tally. A periodic performance-monitoring strobe freezes both tallies into holding registers, which software or downstream logic reads. In the same cycle the strobe restarts both running tallies from zero, so each snapshot covers exactly one monitoring interval.

A mode input chooses what a running tally does once it reaches its ceiling. With the mode input set, the tally stays at the ceiling. With it clear, the tally wraps back to zero. A small vector of alarm inputs covers these conditions: pointer loss, tributary alarm indication, an automatic alarm-insertion request, and multiframe alignment loss. While any one of these alarms is asserted, every tally and every holding register is held at zero.

Top module: `ptr_just_counter`

## Requirements
- R1: While `rst` is high, both holding outputs are 0 from the next clock edge, and both running tallies are 0.
- R2: Increment pulses and decrement pulses are counted in independent tallies, and a pulse of one kind never changes the other tally.
- R3: A strobe with no alarm copies each running tally into its holding output, and the new value appears on the output one clock after the strobe cycle.
- R4: A strobe clears the running tallies, so a second strobe with no pulses in between reports 0.
- R5: With `sat_mode_i` = 1, a running tally that has reached 15 stays at 15 for any further pulses.
- R6: With `sat_mode_i` = 0, a running tally at 15 goes to 0 on the next pulse, so the tally equals the pulse count modulo 16.
- R7: A pulse in the same cycle as a strobe is left out of that snapshot and is counted as 1 in the new interval.
- R8: When any bit of `alarm_i` is high at a clock edge, both holding outputs and both running tallies are 0 after that edge.
- R9: An alarm takes priority over a coincident strobe and over coincident pulses. Neither the snapshot nor the count takes effect.
- R10: Without a strobe, the holding outputs keep their value no matter how many pulses arrive.
- R11: Each of the four `alarm_i` bits forces the zero state on its own (bit 0 pointer loss, bit 1 tributary AIS, bit 2 auto-AIS request, bit 3 multiframe loss).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_pulse_i | input | 1 | One-cycle pointer increment event |
| dec_pulse_i | input | 1 | One-cycle pointer decrement event |
| pm_strobe_i | input | 1 | Monitoring strobe: snapshot and clear |
| sat_mode_i | input | 1 | 1 = saturate at 15, 0 = wrap |
| alarm_i | input | 4 | Alarm sources that force all tallies to zero |
| inc_hold_o | output | 4 | Held increment tally of the last interval |
| dec_hold_o | output | 4 | Held decrement tally of the last interval |

## Verification
The running tallies have no port of their own, so their state can only be seen through a later strobe. The hardest cases are therefore the ones where the hidden state matters. The first is a pulse that coincides with a strobe: it must land in the next interval. The second is an alarm that coincides with a strobe and pulses: it must leave nothing behind. For each case the stimulus first builds a known nonzero tally, then applies the coincident event, then issues a clean strobe to expose what the running tally held. Saturation and wrap are reached with bursts of up to 31 pulses between strobes, under both mode settings.

// File: rtl/pjc_pkg.sv
package pjc_pkg;
  localparam int CNT_W   = 4;
  localparam int N_ALARM = 4;
  localparam int N_CH    = 2;
  typedef enum int { CH_INC = 0, CH_DEC = 1 } pjc_ch_e;
endpackage

// File: rtl/pjc_run_cnt.sv
module pjc_run_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         zero_i,
  input  logic         snap_i,
  input  logic         ev_i,
  input  logic         sat_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || zero_i) begin
      cnt_q <= '0;
    end else if (snap_i) begin
      cnt_q <= ev_i ? ONE : '0;
    end else if (ev_i) begin
      if (cnt_q == TOP) cnt_q <= sat_i ? TOP : '0;
      else              cnt_q <= cnt_q + ONE;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pjc_hold_reg.sv
module pjc_hold_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         zero_i,
  input  logic         snap_i,
  input  logic [W-1:0] run_i,
  output logic [W-1:0] hold_o
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst || zero_i) hold_q <= '0;
    else if (snap_i)   hold_q <= run_i;
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/ptr_just_counter.sv
module ptr_just_counter #(
  parameter int CNT_W   = pjc_pkg::CNT_W,
  parameter int N_ALARM = pjc_pkg::N_ALARM
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inc_pulse_i,
  input  logic               dec_pulse_i,
  input  logic               pm_strobe_i,
  input  logic               sat_mode_i,
  input  logic [N_ALARM-1:0] alarm_i,
  output logic [CNT_W-1:0]   inc_hold_o,
  output logic [CNT_W-1:0]   dec_hold_o
);
  localparam int NCH = pjc_pkg::N_CH;

  logic             force_zero;
  logic [NCH-1:0]   ev;
  logic [CNT_W-1:0] run  [NCH];
  logic [CNT_W-1:0] held [NCH];

  assign force_zero          = |alarm_i;
  assign ev[pjc_pkg::CH_INC] = inc_pulse_i;
  assign ev[pjc_pkg::CH_DEC] = dec_pulse_i;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pjc_run_cnt #(.W(CNT_W)) u_run (
      .clk    (clk),
      .rst    (rst),
      .zero_i (force_zero),
      .snap_i (pm_strobe_i),
      .ev_i   (ev[g]),
      .sat_i  (sat_mode_i),
      .cnt_o  (run[g])
    );
    pjc_hold_reg #(.W(CNT_W)) u_hold (
      .clk    (clk),
      .rst    (rst),
      .zero_i (force_zero),
      .snap_i (pm_strobe_i),
      .run_i  (run[g]),
      .hold_o (held[g])
    );
  end

  assign inc_hold_o = held[pjc_pkg::CH_INC];
  assign dec_hold_o = held[pjc_pkg::CH_DEC];
endmodule

// File: rtl/pjc_chk.sv
module pjc_chk #(
  parameter int CNT_W   = 4,
  parameter int N_ALARM = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               inc_pulse_i,
  input logic               dec_pulse_i,
  input logic               pm_strobe_i,
  input logic [N_ALARM-1:0] alarm_i,
  input logic [CNT_W-1:0]   inc_hold_o,
  input logic [CNT_W-1:0]   dec_hold_o
);
  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (inc_hold_o == '0 && dec_hold_o == '0));

  // R8
  alarm_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (|alarm_i) |=> (inc_hold_o == '0 && dec_hold_o == '0));

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!pm_strobe_i && !(|alarm_i)) |=> ($stable(inc_hold_o) && $stable(dec_hold_o)));

  // R4
  empty_interval_chk: assert property (@(posedge clk) disable iff (rst)
    (pm_strobe_i && !(|alarm_i) && !inc_pulse_i) ##1 (pm_strobe_i && !(|alarm_i))
    |=> (inc_hold_o == '0));

  // R7
  coincident_event_chk: assert property (@(posedge clk) disable iff (rst)
    (pm_strobe_i && !(|alarm_i) && dec_pulse_i) ##1 (pm_strobe_i && !(|alarm_i))
    |=> (dec_hold_o == 1));
endmodule

bind ptr_just_counter pjc_chk #(.CNT_W(CNT_W), .N_ALARM(N_ALARM)) u_pjc_chk (
  .clk         (clk),
  .rst         (rst),
  .inc_pulse_i (inc_pulse_i),
  .dec_pulse_i (dec_pulse_i),
  .pm_strobe_i (pm_strobe_i),
  .alarm_i     (alarm_i),
  .inc_hold_o  (inc_hold_o),
  .dec_hold_o  (dec_hold_o)
);

// File: tb/tb_ptr_just_counter.sv
`timescale 1ns/1ps
module tb_ptr_just_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inc_p = 1'b0, dec_p = 1'b0, stb = 1'b0, sat = 1'b0;
  logic [3:0] alarm = '0;
  logic [3:0] inc_h, dec_h;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ptr_just_counter dut (
    .clk(clk), .rst(rst), .inc_pulse_i(inc_p), .dec_pulse_i(dec_p),
    .pm_strobe_i(stb), .sat_mode_i(sat), .alarm_i(alarm),
    .inc_hold_o(inc_h), .dec_hold_o(dec_h)
  );

  // {sat, n_inc[5], n_dec[5], exp_inc[4], exp_dec[4]}
  localparam int NV = 6;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 5'd3,  5'd5,  4'd3,  4'd5 },
    {1'b1, 5'd15, 5'd0,  4'd15, 4'd0 },
    {1'b1, 5'd20, 5'd16, 4'd15, 4'd15},
    {1'b0, 5'd16, 5'd17, 4'd0,  4'd1 },
    {1'b0, 5'd15, 5'd31, 4'd15, 4'd15},
    {1'b1, 5'd0,  5'd7,  4'd0,  4'd7 }
  };

  task automatic check(string req, logic [3:0] ei, logic [3:0] ed);
    checks++;
    if (inc_h !== ei || dec_h !== ed) begin
      errors++;
      $display("FAIL %s: inc_hold=%0d dec_hold=%0d expected inc=%0d dec=%0d",
               req, inc_h, dec_h, ei, ed);
    end
  endtask

  // one cycle of stimulus: drive at negedge, settle to next negedge
  task automatic step(logic i, logic d, logic s, logic [3:0] a);
    @(negedge clk);
    inc_p = i; dec_p = d; stb = s; alarm = a;
    @(negedge clk);
    inc_p = 0; dec_p = 0; stb = 0; alarm = '0;
  endtask

  task automatic burst(int ni, int nd);
    for (int k = 0; k < 32; k++)
      if (k < ni || k < nd) step(k < ni, k < nd, 1'b0, 4'd0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 4'd0, 4'd0);
    rst = 1'b0;

    // table: R2 R3 R5 R6
    for (int v = 0; v < NV; v++) begin
      sat = VEC[v][18];
      burst(int'(VEC[v][17:13]), int'(VEC[v][12:8]));
      step(0, 0, 1, 4'd0);
      check($sformatf("R2/R3/R5/R6 vector %0d", v), VEC[v][7:4], VEC[v][3:0]);
    end
    sat = 1'b0;

    // R4: empty interval reports zero
    burst(2, 2);
    step(0, 0, 1, 4'd0);
    step(0, 0, 1, 4'd0);
    check("R4 cleared after strobe", 4'd0, 4'd0);

    // R7: pulse coincident with strobe
    burst(2, 3);
    step(1, 1, 1, 4'd0);
    check("R7 snapshot excludes coincident pulse", 4'd2, 4'd3);
    step(0, 0, 1, 4'd0);
    check("R7 coincident pulse counted as 1", 4'd1, 4'd1);

    // R10: holding stable under events
    burst(6, 4);
    check("R10 hold unchanged by events", 4'd1, 4'd1);
    burst(3, 0);
    check("R10 hold unchanged by more events", 4'd1, 4'd1);
    step(0, 0, 1, 4'd0);
    check("R10 next snapshot", 4'd9, 4'd4);

    // R8 R9 R11: each alarm source alone, coincident with strobe and pulses
    for (int j = 0; j < 4; j++) begin
      burst(4, 2);
      step(0, 0, 1, 4'd0);
      check($sformatf("R11 pre-alarm snapshot src %0d", j), 4'd4, 4'd2);
      burst(3, 5);
      step(1, 1, 1, 4'(1 << j));
      check($sformatf("R8/R9/R11 alarm src %0d zeroes hold", j), 4'd0, 4'd0);
      step(0, 0, 1, 4'd0);
      check($sformatf("R9 running cleared by alarm src %0d", j), 4'd0, 4'd0);
    end

    // R1: reset mid-interval clears running and holding
    burst(5, 5);
    step(0, 0, 1, 4'd0);
    burst(2, 2);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 reset clears hold", 4'd0, 4'd0);
    step(0, 0, 1, 4'd0);
    check("R1 reset clears running", 4'd0, 4'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule